// File: doc/BRIEF.md
# Descriptor-Driven DMA Address Sequencer

This block is the transfer control engine of a single DMA channel. A transfer descriptor is loaded in one cycle. It holds the starting source and destination addresses, a signed byte offset for each side, an element size and a modulo window for each side, a byte count per minor loop, a 15-bit iteration count, and a signed last-adjustment for each side. It also holds two control bits: interrupt on completion and auto-disable on completion.

Service is requested in one of two ways. Software can pulse `start`, which sets a pending flag that the engine clears once it accepts the request. Hardware can raise `hw_req`, which is honoured only while the channel's request enable is set. Each accepted request runs one minor loop: a sequence of read/write element pairs on a simple memory port. After every access, the matching address advances by its offset and wraps inside its modulo window. At the end of the minor loop the current iteration count is decremented.

When the last iteration finishes, the engine enters a closing step:
- it adds the last-adjustments to both addresses;
- it reloads the iteration count from the beginning count;
- it sets the done flag;
- if enabled, it raises the interrupt;
- if enabled, it clears the request enable.

Top module: `xfer_seq`

## Requirements
- R1: After synchronous reset, `active`, `done`, `irq`, `req_en`, `start_pend`, `mem_rd` and `mem_wr` are 0 and `cur_iter` is 0.
- R2: A descriptor load copies `desc_iter` into both the current and the beginning iteration count, so `cur_iter` shows the loaded value in the next cycle. The load also clears `done`.
- R3: Each serviced minor loop is a series of pairs. Each pair is one read cycle (`mem_rd`, `mem_size` = source size code) followed directly by one write cycle (`mem_wr`, `mem_size` = destination size code), and the write data equals the data read. Size codes are 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for 64-bit. The number of pairs is the minor byte count divided by 2^(source size code), rounded up.
- R4: The source address advances by the signed 16-bit source offset after each read, and the destination address advances by the destination offset after each write. A negative offset lowers the address.
- R5: With a modulo value M other than 0, a step changes only address bits M-1..0. The bits above them keep their value. With M = 0, the full address is stepped.
- R6: A minor byte count of 0 means 2^32 bytes, so the minor loop keeps running far past any small count.
- R7: `cur_iter` decrements by one per completed minor loop. After the final minor loop, it returns to the beginning count. Counts of 0 and 1 both end the major loop after one minor loop.
- R8: At major loop completion, the signed 32-bit source last-adjustment is added to the source address, and the destination last-adjustment is added to the destination address.
- R9: Major loop completion sets `done`. It sets `irq` only if the descriptor's interrupt bit is 1. `done_clr` clears `done` and `int_clr` clears `irq`.
- R10: `req_en` is set by `req_en_set` and cleared by `req_en_clr`. While `req_en` is 1, a high `hw_req` starts service, and while it is 0, `hw_req` has no effect. If the auto-disable bit is set, major loop completion clears `req_en`.
- R11: A `start` pulse sets `start_pend` in the next cycle. The engine accepts it one cycle later, clearing `start_pend` as the first read is issued.
- R12: `active` is 1 from the first read until the minor loop (and any closing step) ends. A read and a write never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Load the descriptor fields below |
| desc_src | input | 32 | Starting source address |
| desc_dst | input | 32 | Starting destination address |
| desc_soff | input | 16 | Signed source offset in bytes |
| desc_doff | input | 16 | Signed destination offset in bytes |
| desc_ssize | input | 2 | Source element size code |
| desc_dsize | input | 2 | Destination element size code |
| desc_smod | input | 5 | Source modulo bit count (0 = off) |
| desc_dmod | input | 5 | Destination modulo bit count (0 = off) |
| desc_nbytes | input | 32 | Bytes per minor loop (0 = 2^32) |
| desc_iter | input | 15 | Iteration count of the major loop |
| desc_slast | input | 32 | Signed source last-adjustment |
| desc_dlast | input | 32 | Signed destination last-adjustment |
| desc_intmaj | input | 1 | Raise interrupt at major completion |
| desc_dreq | input | 1 | Clear request enable at major completion |
| start | input | 1 | Software service request pulse |
| req_en_set | input | 1 | Set the hardware request enable |
| req_en_clr | input | 1 | Clear the hardware request enable |
| hw_req | input | 1 | Hardware service request level |
| done_clr | input | 1 | Clear the done flag |
| int_clr | input | 1 | Clear the interrupt |
| mem_rdata | input | 64 | Read data, valid in the read cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_addr | output | 32 | Access address |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 64 | Write data |
| active | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop complete |
| irq | output | 1 | Completion interrupt |
| req_en | output | 1 | Hardware request enable |
| start_pend | output | 1 | Software request not yet accepted |
| cur_iter | output | 15 | Current iteration count |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
The cycle-level assertions cover the following:
- that read and write strobes never overlap;
- that every read is followed by a write;
- that memory traffic happens only while `active` is high;
- that the iteration count holds while the engine is idle;
- that an interrupt never rises without `done`;
- that auto-disable takes effect at completion.

Only the bench scenarios can show the address arithmetic, namely signed steps, modulo wrapping and last-adjustments. The same applies to the number of pairs per minor loop for every size combination, the count reload after the final loop, the 2^32 meaning of a zero byte count, and whether a disabled hardware request is ignored.

// File: rtl/xfer_seq_pkg.sv
package xfer_seq_pkg;
    localparam int AW = 32;  // address width
    localparam int OW = 16;  // offset width
    localparam int DW = 64;  // data width
    localparam int IW = 15;  // iteration count width
    localparam int MW = 5;   // modulo field width
    localparam int NW = 32;  // minor byte count width

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } elem_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic [OW-1:0] soff;
        logic [OW-1:0] doff;
        elem_size_e    ssize;
        elem_size_e    dsize;
        logic [MW-1:0] smod;
        logic [MW-1:0] dmod;
        logic [NW-1:0] nbytes;
        logic [AW-1:0] slast;
        logic [AW-1:0] dlast;
        logic          intmaj;
        logic          dreq;
    } xfer_desc_t;

    // Keep bits above the modulo window from the current address.
    function automatic logic [AW-1:0] wrap_step(input logic [AW-1:0] cur,
                                                input logic [AW-1:0] sum,
                                                input logic [MW-1:0] m);
        logic [AW-1:0] keep_low;
        keep_low = (m == '0) ? '1 : ((AW'(1) << m) - AW'(1));
        return (cur & ~keep_low) | (sum & keep_low);
    endfunction

    function automatic logic [NW:0] elem_bytes(input elem_size_e s);
        return (NW+1)'(1) << s;
    endfunction
endpackage

// File: rtl/xfer_addr_gen.sv
module xfer_addr_gen
    import xfer_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    input  logic [OW-1:0] offset,
    input  logic [MW-1:0] modulo,
    input  logic          adjust,
    input  logic [AW-1:0] adj,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] off_ext;
    logic [AW-1:0] stepped;

    assign off_ext = {{(AW-OW){offset[OW-1]}}, offset};
    assign stepped = wrap_step(addr, addr + off_ext, modulo);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_addr;
        end else if (step) begin
            addr <= stepped;
        end else if (adjust) begin
            addr <= addr + adj;
        end
    end
endmodule

// File: rtl/xfer_seq_ctrl.sv
module xfer_seq_ctrl
    import xfer_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_load,
    input  logic [IW-1:0] desc_iter,
    input  logic [NW-1:0] nbytes,
    input  elem_size_e    ssize,
    input  logic          intmaj,
    input  logic          dreq,
    input  logic          start,
    input  logic          req_en_set,
    input  logic          req_en_clr,
    input  logic          hw_req,
    input  logic          done_clr,
    input  logic          int_clr,
    output seq_state_e    state,
    output logic          done,
    output logic          irq,
    output logic          req_en,
    output logic          start_pend,
    output logic [IW-1:0] cur_iter
);
    logic [IW-1:0] begin_iter;
    logic [NW:0]   remain;
    logic [NW:0]   step_b;
    logic          accept;
    logic          last_pair;
    logic          last_minor;
    logic          closing;

    assign step_b     = elem_bytes(ssize);
    assign accept     = (state == ST_IDLE) && (start_pend || (req_en && hw_req));
    assign last_pair  = (state == ST_WR) && (remain <= step_b);
    assign last_minor = (cur_iter <= IW'(1));
    assign closing    = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            remain     <= '0;
            cur_iter   <= '0;
            begin_iter <= '0;
            start_pend <= 1'b0;
            req_en     <= 1'b0;
            done       <= 1'b0;
            irq        <= 1'b0;
        end else begin
            start_pend <= (start_pend && !accept) || start;

            if (closing && dreq)  req_en <= 1'b0;
            else if (req_en_clr)  req_en <= 1'b0;
            else if (req_en_set)  req_en <= 1'b1;

            if (closing)                     done <= 1'b1;
            else if (done_clr || desc_load)  done <= 1'b0;

            if (closing && intmaj)  irq <= 1'b1;
            else if (int_clr)       irq <= 1'b0;

            if (desc_load) begin
                cur_iter   <= desc_iter;
                begin_iter <= desc_iter;
            end else if (last_pair) begin
                cur_iter <= cur_iter - IW'(1);
            end else if (closing) begin
                cur_iter <= begin_iter;
            end

            case (state)
                ST_IDLE: if (accept) begin
                    remain <= (nbytes == '0) ? ((NW+1)'(1) << NW) : {1'b0, nbytes};
                    state  <= ST_RD;
                end
                ST_RD:   state <= ST_WR;
                ST_WR: begin
                    remain <= remain - step_b;
                    if (last_pair) state <= last_minor ? ST_FIN : ST_IDLE;
                    else           state <= ST_RD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          desc_load,
    input  logic [31:0]   desc_src,
    input  logic [31:0]   desc_dst,
    input  logic [15:0]   desc_soff,
    input  logic [15:0]   desc_doff,
    input  logic [1:0]    desc_ssize,
    input  logic [1:0]    desc_dsize,
    input  logic [4:0]    desc_smod,
    input  logic [4:0]    desc_dmod,
    input  logic [31:0]   desc_nbytes,
    input  logic [14:0]   desc_iter,
    input  logic [31:0]   desc_slast,
    input  logic [31:0]   desc_dlast,
    input  logic          desc_intmaj,
    input  logic          desc_dreq,
    input  logic          start,
    input  logic          req_en_set,
    input  logic          req_en_clr,
    input  logic          hw_req,
    input  logic          done_clr,
    input  logic          int_clr,
    input  logic [63:0]   mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [31:0]   mem_addr,
    output logic [1:0]    mem_size,
    output logic [63:0]   mem_wdata,
    output logic          active,
    output logic          done,
    output logic          irq,
    output logic          req_en,
    output logic          start_pend,
    output logic [14:0]   cur_iter,
    output logic [31:0]   src_addr,
    output logic [31:0]   dst_addr
);
    localparam int NSIDE = 2;

    xfer_desc_t    desc_q;
    seq_state_e    state;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_q <= '0;
        end else if (desc_load) begin
            desc_q.soff   <= desc_soff;
            desc_q.doff   <= desc_doff;
            desc_q.ssize  <= elem_size_e'(desc_ssize);
            desc_q.dsize  <= elem_size_e'(desc_dsize);
            desc_q.smod   <= desc_smod;
            desc_q.dmod   <= desc_dmod;
            desc_q.nbytes <= desc_nbytes;
            desc_q.slast  <= desc_slast;
            desc_q.dlast  <= desc_dlast;
            desc_q.intmaj <= desc_intmaj;
            desc_q.dreq   <= desc_dreq;
        end
    end

    xfer_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .desc_load  (desc_load),
        .desc_iter  (desc_iter),
        .nbytes     (desc_q.nbytes),
        .ssize      (desc_q.ssize),
        .intmaj     (desc_q.intmaj),
        .dreq       (desc_q.dreq),
        .start      (start),
        .req_en_set (req_en_set),
        .req_en_clr (req_en_clr),
        .hw_req     (hw_req),
        .done_clr   (done_clr),
        .int_clr    (int_clr),
        .state      (state),
        .done       (done),
        .irq        (irq),
        .req_en     (req_en),
        .start_pend (start_pend),
        .cur_iter   (cur_iter)
    );

    // Side 0 is the source, side 1 the destination.
    logic [AW-1:0] init_a [NSIDE];
    logic [AW-1:0] adj_a  [NSIDE];
    logic [AW-1:0] addr_a [NSIDE];
    logic [OW-1:0] off_a  [NSIDE];
    logic [MW-1:0] mod_a  [NSIDE];
    logic          step_a [NSIDE];

    assign init_a[0] = desc_src;
    assign init_a[1] = desc_dst;
    assign adj_a[0]  = desc_q.slast;
    assign adj_a[1]  = desc_q.dlast;
    assign off_a[0]  = desc_q.soff;
    assign off_a[1]  = desc_q.doff;
    assign mod_a[0]  = desc_q.smod;
    assign mod_a[1]  = desc_q.dmod;
    assign step_a[0] = (state == ST_RD);
    assign step_a[1] = (state == ST_WR);

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        xfer_addr_gen u_addr (
            .clk       (clk),
            .rst       (rst),
            .load      (desc_load),
            .load_addr (init_a[s]),
            .step      (step_a[s]),
            .offset    (off_a[s]),
            .modulo    (mod_a[s]),
            .adjust    (state == ST_FIN),
            .adj       (adj_a[s]),
            .addr      (addr_a[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)                  data_q <= '0;
        else if (state == ST_RD)  data_q <= mem_rdata;
    end

    assign mem_rd    = (state == ST_RD);
    assign mem_wr    = (state == ST_WR);
    assign mem_addr  = mem_wr ? addr_a[1] : addr_a[0];
    assign mem_size  = mem_wr ? desc_q.dsize : desc_q.ssize;
    assign mem_wdata = data_q;
    assign active    = (state != ST_IDLE);
    assign src_addr  = addr_a[0];
    assign dst_addr  = addr_a[1];
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        active,
    input logic        desc_load,
    input logic [14:0] cur_iter,
    input logic        done,
    input logic        irq,
    input logic        req_en,
    input logic        dreq
);
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    a_r12_access_active: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> active);

    a_r3_read_then_write: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> mem_wr);

    a_r7_iter_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!active && !desc_load) |=> $stable(cur_iter));

    a_r9_irq_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> done);

    a_r10_auto_disable: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && dreq) |-> !req_en);
endmodule

bind xfer_seq xfer_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .active    (active),
    .desc_load (desc_load),
    .cur_iter  (cur_iter),
    .done      (done),
    .irq       (irq),
    .req_en    (req_en),
    .dreq      (desc_q.dreq)
);

// File: tb/test_xfer_seq.sv
`timescale 1ns/1ps
module test_xfer_seq;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst = 1'b1;
    logic        desc_load = 0, start = 0, req_en_set = 0, req_en_clr = 0;
    logic        hw_req = 0, done_clr = 0, int_clr = 0;
    logic [31:0] desc_src = 0, desc_dst = 0, desc_nbytes = 0, desc_slast = 0, desc_dlast = 0;
    logic [15:0] desc_soff = 0, desc_doff = 0;
    logic [1:0]  desc_ssize = 0, desc_dsize = 0;
    logic [4:0]  desc_smod = 0, desc_dmod = 0;
    logic [14:0] desc_iter = 0;
    logic        desc_intmaj = 0, desc_dreq = 0;
    logic [63:0] mem_rdata;
    logic        mem_rd, mem_wr, active, done, irq, req_en, start_pend;
    logic [31:0] mem_addr, src_addr, dst_addr;
    logic [1:0]  mem_size;
    logic [63:0] mem_wdata;
    logic [14:0] cur_iter;

    assign mem_rdata = {~mem_addr, mem_addr};

    xfer_seq i_xfer_seq (.*);

    int n_chk = 0, n_fail = 0;
    int pairs = 0;
    logic [31:0] exp_src, exp_dst;
    logic [63:0] held;
    int cfg_so, cfg_do, cfg_sm, cfg_dm;
    logic [1:0] cfg_ss, cfg_ds;
    bit saw_active;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bwrap(input logic [31:0] a, input int off, input int m);
        longint unsigned sum;
        longint unsigned p;
        sum = (longint'(a) + longint'(off)) & 64'hFFFF_FFFF;
        if (m == 0) return sum[31:0];
        p = 64'd1 << m;
        return 32'((longint'(a) - (longint'(a) % p)) + (sum % p));
    endfunction

    // Access monitor: address, size and data of every access.
    always @(negedge clk) begin
        if (!rst) begin
            if (active) saw_active = 1;
            if (mem_rd) begin
                chk(mem_addr == exp_src, "R4/R5 read addr", mem_addr, exp_src);
                chk(mem_size == cfg_ss, "R3 read size", mem_size, cfg_ss);
                held = mem_rdata;
                exp_src = bwrap(exp_src, cfg_so, cfg_sm);
                pairs++;
            end
            if (mem_wr) begin
                chk(mem_addr == exp_dst, "R4/R5 write addr", mem_addr, exp_dst);
                chk(mem_size == cfg_ds, "R3 write size", mem_size, cfg_ds);
                chk(mem_wdata == held, "R3 write data", mem_wdata, held);
                exp_dst = bwrap(exp_dst, cfg_do, cfg_dm);
            end
        end
    end

    task automatic load_desc(input logic [31:0] s, input logic [31:0] d, input int so, input int dof,
                             input logic [1:0] ss, input logic [1:0] ds, input int sm, input int dm,
                             input logic [31:0] nb, input int it, input logic [31:0] sl,
                             input logic [31:0] dl, input logic im, input logic dr);
        @(negedge clk);
        desc_src = s; desc_dst = d; desc_soff = 16'(so); desc_doff = 16'(dof);
        desc_ssize = ss; desc_dsize = ds; desc_smod = 5'(sm); desc_dmod = 5'(dm);
        desc_nbytes = nb; desc_iter = 15'(it); desc_slast = sl; desc_dlast = dl;
        desc_intmaj = im; desc_dreq = dr; desc_load = 1;
        exp_src = s; exp_dst = d; cfg_so = so; cfg_do = dof; cfg_ss = ss; cfg_ds = ds;
        cfg_sm = sm; cfg_dm = dm;
        @(negedge clk);
        desc_load = 0;
        chk(cur_iter == 15'(it), "R2 count loaded", cur_iter, it);
        chk(done == 0, "R2 load clears done", done, 0);
    endtask

    task automatic service();
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(start_pend == 1 && active == 0, "R11 pending set", {start_pend, active}, 2'b10);
        @(negedge clk);
        chk(start_pend == 0 && active == 1 && mem_rd == 1, "R11/R12 accepted",
            {start_pend, active, mem_rd}, 3'b011);
        while (active) @(negedge clk);
    endtask

    task automatic check_idle_state(input string tag);
        chk({active, done, irq, req_en, start_pend, mem_rd, mem_wr} == 7'b0, tag,
            {active, done, irq, req_en, start_pend, mem_rd, mem_wr}, 0);
        chk(cur_iter == 0, tag, cur_iter, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_idle_state("R1 reset state");

        // Sweep every source/destination size combination.
        for (int ss = 0; ss < 4; ss++) begin
            for (int ds = 0; ds < 4; ds++) begin
                int so, dof, npairs, nb;
                logic [31:0] sl, dl;
                nb = 24 + ss;
                so = ((ss + ds) % 2 == 0) ? (1 << ss) : -(1 << ss);
                dof = -so * ((ds % 2) + 1);
                sl = 32'(-(ss * 16 + 5));
                dl = 32'h0000_0100 + 32'(ds);
                npairs = (nb + (1 << ss) - 1) >> ss;
                load_desc(32'h1000_0F30 + 32'(ss * 8), 32'h2000_07F0 - 32'(ds * 4), so, dof,
                          2'(ss), 2'(ds), ds * 2, (ss == 3) ? 0 : ss + 3, 32'(nb), 2, sl, dl,
                          ds[0], 1'b0);
                for (int k = 1; k <= 2; k++) begin
                    pairs = 0;
                    service();
                    chk(pairs == npairs, "R3 pair count", pairs, npairs);
                    if (k == 1) begin
                        chk(cur_iter == 1, "R7 decrement", cur_iter, 1);
                        chk(done == 0, "R9 no done mid-loop", done, 0);
                    end else begin
                        exp_src = exp_src + sl;
                        exp_dst = exp_dst + dl;
                        chk(src_addr == exp_src, "R8 source adjust", src_addr, exp_src);
                        chk(dst_addr == exp_dst, "R8 dest adjust", dst_addr, exp_dst);
                        chk(cur_iter == 2, "R7 reload", cur_iter, 2);
                        chk(done == 1, "R9 done set", done, 1);
                        chk(irq == ds[0], "R9 irq follows enable", irq, ds[0]);
                    end
                end
                @(negedge clk); done_clr = 1; int_clr = 1;
                @(negedge clk); done_clr = 0; int_clr = 0;
                chk(done == 0 && irq == 0, "R9 flags cleared", {done, irq}, 0);
            end
        end

        // Hardware requests with auto-disable.
        load_desc(32'h3000_0000, 32'h4000_0000, 4, 4, 2'd2, 2'd2, 0, 0, 32'd8, 2,
                  32'hFFFF_FFF0, 32'h10, 1'b1, 1'b1);
        @(negedge clk); req_en_set = 1;
        @(negedge clk); req_en_set = 0;
        chk(req_en == 1, "R10 enable set", req_en, 1);
        pairs = 0;
        hw_req = 1;
        repeat (40) @(negedge clk);
        chk(pairs == 4, "R10 hw requests served", pairs, 4);
        chk(req_en == 0, "R10 auto-disable", req_en, 0);
        chk(done == 1 && irq == 1, "R9 done and irq", {done, irq}, 2'b11);
        exp_src = exp_src + 32'hFFFF_FFF0;
        exp_dst = exp_dst + 32'h10;
        chk(src_addr == exp_src, "R8 hw source adjust", src_addr, exp_src);
        saw_active = 0;
        repeat (20) @(negedge clk);
        chk(saw_active == 0 && cur_iter == 2, "R10 disabled request ignored",
            {saw_active, cur_iter}, {1'b0, 15'd2});
        hw_req = 0;
        @(negedge clk); req_en_set = 1;
        @(negedge clk); req_en_set = 0; req_en_clr = 1;
        @(negedge clk); req_en_clr = 0;
        chk(req_en == 0, "R10 enable cleared", req_en, 0);

        // Single iteration count.
        load_desc(32'h0000_0100, 32'h0000_0200, -2, 2, 2'd1, 2'd1, 0, 0, 32'd4, 1,
                  32'h4, 32'hC, 1'b0, 1'b0);
        pairs = 0;
        service();
        chk(pairs == 2 && done == 1 && cur_iter == 1, "R7 single iteration",
            {pairs[7:0], done, cur_iter}, {8'd2, 1'b1, 15'd1});

        // Zero byte count means 2^32 bytes.
        load_desc(32'h5000_0000, 32'h6000_0000, 1, 1, 2'd0, 2'd0, 0, 0, 32'd0, 1,
                  32'h0, 32'h0, 1'b0, 1'b0);
        pairs = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        repeat (300) @(negedge clk);
        chk(active == 1 && pairs >= 140, "R6 zero count runs on", {active, pairs[15:0]}, 1);

        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        @(negedge clk);
        check_idle_state("R1 reset after run");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule